// File: doc/BRIEF.md
# Multi-Sector Transfer Address Sequencer

This block walks a disk-style multi-sector read or write one sector at a time. When a command starts, it captures the starting address and the sector count from the task-file fields, together with the drive geometry. It then issues one sector request at a time to a media interface. Each request carries the current address. The media side answers each request with a done strobe and two qualifiers, one for a correctable error and one for an uncorrectable error.

After each sector that completes without an uncorrectable error, the block advances the address and decrements the remaining count. The address advances either as a flat 28-bit logical block number or as a cylinder/head/sector triple wrapped by the geometry. A correctable error is recorded, and the walk continues. An uncorrectable error stops the walk at once. The failing address and the number of sectors still owed stay visible for the host, so that it can retry from that point. Each command ends with a one-cycle done pulse.

Top module: `sector_walker`

## Requirements
- R1: A captured count of 1 to 255 requests that many sectors. A captured count of 0 requests 256 sectors, and rem_o reads 256 in the cycle after start.
- R2: The address captured at start is packed into addr_o as follows: [7:0] is the sector field, [15:8] is cylinder low, [23:16] is cylinder high and [27:24] is the head field. In CHS mode the 16-bit cylinder therefore occupies [23:8].
- R3: In LBA mode (lba_mode_i=1 at start), each successful sector adds 1 to addr_o, modulo 2^28.
- R4: In CHS mode, each successful sector changes the address as follows. If the sector field equals spt_i, the sector field becomes 1 and the head advances; otherwise the sector field increments. When the head advances to the value heads_i, it wraps to 0 and the cylinder increments, modulo 2^16.
- R5: Each successful sector decrements rem_o by 1. A transfer that finishes without an uncorrectable error ends with rem_o=0 and err_o=0.
- R6: A sector reported with sec_corr_i=1 and sec_unc_i=0 sets corr_o, which stays set until the next start, and the transfer continues.
- R7: A sector reported with sec_unc_i=1 sets unc_o and err_o and ends the transfer. addr_o keeps the failing sector's address, and rem_o keeps the count that includes the failing sector.
- R8: req_o is a one-cycle pulse, and only one request is outstanding at a time. The first pulse comes in the cycle after start. After each non-final sector, the next pulse comes in the cycle after sec_done_i is sampled. sec_done_i has no effect while no request is outstanding.
- R9: done_o pulses for one cycle, in the cycle after the final sec_done_i, whether the transfer succeeds or fails.
- R10: The inputs start_i, address, count, mode and geometry are sampled only on a start taken while idle. A start while busy is ignored. A start clears corr_o, unc_o and err_o.
- R11: After reset, addr_o=0, rem_o=0, all flags are 0, and req_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken while idle only) |
| lba_mode_i | input | 1 | 1 = logical block addressing, 0 = cylinder/head/sector |
| sec_num_i | input | 8 | Starting sector field |
| cyl_lo_i | input | 8 | Starting cylinder low byte |
| cyl_hi_i | input | 8 | Starting cylinder high byte |
| head_i | input | 4 | Starting head field |
| count_i | input | 8 | Sector count (0 = 256) |
| spt_i | input | 8 | Sectors per track (CHS) |
| heads_i | input | 5 | Number of heads, 1 to 16 (CHS) |
| sec_done_i | input | 1 | Media reports the outstanding sector finished |
| sec_corr_i | input | 1 | With sec_done_i: correctable error occurred |
| sec_unc_i | input | 1 | With sec_done_i: uncorrectable error occurred |
| req_o | output | 1 | One-cycle sector request |
| addr_o | output | 28 | Current address |
| rem_o | output | 9 | Sectors still to transfer |
| corr_o | output | 1 | Correctable error seen in this command |
| unc_o | output | 1 | Uncorrectable error ended the command |
| err_o | output | 1 | Command ended in error |
| done_o | output | 1 | One-cycle end-of-command pulse |

## Verification
Random transfers mix the two addressing modes. They use random geometry, random start points and random per-sector error flags, so the CHS carries from sector to head and from head to cylinder are separated from the plain LBA increment. Directed runs cover three boundaries. A start sector equal to the track length on the last head checks that the cylinder carries. An LBA start just below a byte boundary checks the carry into the next byte. A count of 0 must yield exactly 256 requests. Other directed runs place a correctable error mid-transfer, which must not stop the walk, and an uncorrectable error on an inner sector, which must freeze the address and count at that sector. Stray start pulses and done strobes, given while busy or idle, show that neither disturbs the sequence.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_ISSUE = 2'd1,
        SW_WAIT  = 2'd2
    } sw_state_e;

endpackage

// File: rtl/sw_load_decode.sv
// Builds the initial packed address and the 256-aware sector total.
module sw_load_decode #(
    parameter int SEC_W  = 8,
    parameter int CYL_W  = 16,
    parameter int HEAD_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic [SEC_W-1:0]          sec_i,
    input  logic [CYL_W/2-1:0]        cyl_lo_i,
    input  logic [CYL_W/2-1:0]        cyl_hi_i,
    input  logic [HEAD_W-1:0]         head_i,
    input  logic [CNT_W-1:0]          count_i,
    output logic [SEC_W+CYL_W+HEAD_W-1:0] addr_o,
    output logic [CNT_W:0]            total_o
);
    localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    always_comb begin
        addr_o  = {head_i, cyl_hi_i, cyl_lo_i, sec_i};
        total_o = (count_i == '0) ? FULL_CNT : {1'b0, count_i};
    end

endmodule

// File: rtl/sw_addr_step.sv
// Next-address arithmetic for both addressing modes.
module sw_addr_step #(
    parameter int SEC_W  = 8,
    parameter int CYL_W  = 16,
    parameter int HEAD_W = 4
) (
    input  logic [SEC_W+CYL_W+HEAD_W-1:0] addr_i,
    input  logic                          lba_i,
    input  logic [SEC_W-1:0]              spt_i,
    input  logic [HEAD_W:0]               heads_i,
    output logic [SEC_W+CYL_W+HEAD_W-1:0] addr_o
);
    localparam int ADDR_W   = SEC_W + CYL_W + HEAD_W;
    localparam int CYL_LSB  = SEC_W;
    localparam int HEAD_LSB = SEC_W + CYL_W;

    logic [SEC_W-1:0]  sec_cur, sec_nxt;
    logic [CYL_W-1:0]  cyl_cur, cyl_nxt;
    logic [HEAD_W-1:0] head_cur, head_nxt;
    logic [HEAD_W:0]   head_inc;
    logic [ADDR_W-1:0] lba_nxt;

    always_comb begin
        sec_cur  = addr_i[SEC_W-1:0];
        cyl_cur  = addr_i[CYL_LSB +: CYL_W];
        head_cur = addr_i[HEAD_LSB +: HEAD_W];
        head_inc = {1'b0, head_cur} + {{HEAD_W{1'b0}}, 1'b1};
        sec_nxt  = sec_cur;
        cyl_nxt  = cyl_cur;
        head_nxt = head_cur;
        if (sec_cur == spt_i) begin
            sec_nxt = {{(SEC_W-1){1'b0}}, 1'b1};
            if (head_inc == heads_i) begin
                head_nxt = '0;
                cyl_nxt  = cyl_cur + {{(CYL_W-1){1'b0}}, 1'b1};
            end else begin
                head_nxt = head_inc[HEAD_W-1:0];
            end
        end else begin
            sec_nxt = sec_cur + {{(SEC_W-1){1'b0}}, 1'b1};
        end
        lba_nxt = addr_i + {{(ADDR_W-1){1'b0}}, 1'b1};
        addr_o  = lba_i ? lba_nxt : {head_nxt, cyl_nxt, sec_nxt};
    end

endmodule

// File: rtl/sector_walker.sv
module sector_walker
    import sw_pkg::*;
#(
    parameter int SEC_W  = 8,
    parameter int CYL_W  = 16,
    parameter int HEAD_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          lba_mode_i,
    input  logic [SEC_W-1:0]              sec_num_i,
    input  logic [CYL_W/2-1:0]            cyl_lo_i,
    input  logic [CYL_W/2-1:0]            cyl_hi_i,
    input  logic [HEAD_W-1:0]             head_i,
    input  logic [CNT_W-1:0]              count_i,
    input  logic [SEC_W-1:0]              spt_i,
    input  logic [HEAD_W:0]               heads_i,
    input  logic                          sec_done_i,
    input  logic                          sec_corr_i,
    input  logic                          sec_unc_i,
    output logic                          req_o,
    output logic [SEC_W+CYL_W+HEAD_W-1:0] addr_o,
    output logic [CNT_W:0]                rem_o,
    output logic                          corr_o,
    output logic                          unc_o,
    output logic                          err_o,
    output logic                          done_o
);
    localparam int ADDR_W = SEC_W + CYL_W + HEAD_W;
    localparam logic [CNT_W:0] ONE_CNT = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        sw_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W:0]    rem;
        logic              lba;
        logic [SEC_W-1:0]  spt;
        logic [HEAD_W:0]   heads;
        logic              corr;
        logic              unc;
        logic              err;
        logic              done;
    } sw_regs_t;

    sw_regs_t r_q, r_d;

    logic [ADDR_W-1:0] load_addr;
    logic [CNT_W:0]    load_total;
    logic [ADDR_W-1:0] step_addr;

    sw_load_decode #(
        .SEC_W(SEC_W), .CYL_W(CYL_W), .HEAD_W(HEAD_W), .CNT_W(CNT_W)
    ) u_load (
        .sec_i   (sec_num_i),
        .cyl_lo_i(cyl_lo_i),
        .cyl_hi_i(cyl_hi_i),
        .head_i  (head_i),
        .count_i (count_i),
        .addr_o  (load_addr),
        .total_o (load_total)
    );

    sw_addr_step #(
        .SEC_W(SEC_W), .CYL_W(CYL_W), .HEAD_W(HEAD_W)
    ) u_step (
        .addr_i (r_q.addr),
        .lba_i  (r_q.lba),
        .spt_i  (r_q.spt),
        .heads_i(r_q.heads),
        .addr_o (step_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            SW_IDLE: begin
                if (start_i) begin
                    r_d.st    = SW_ISSUE;
                    r_d.addr  = load_addr;
                    r_d.rem   = load_total;
                    r_d.lba   = lba_mode_i;
                    r_d.spt   = spt_i;
                    r_d.heads = heads_i;
                    r_d.corr  = 1'b0;
                    r_d.unc   = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            SW_ISSUE: begin
                r_d.st = SW_WAIT;
            end
            SW_WAIT: begin
                if (sec_done_i) begin
                    if (sec_unc_i) begin
                        r_d.unc  = 1'b1;
                        r_d.err  = 1'b1;
                        r_d.done = 1'b1;
                        r_d.st   = SW_IDLE;
                    end else begin
                        r_d.corr = r_q.corr | sec_corr_i;
                        r_d.addr = step_addr;
                        r_d.rem  = r_q.rem - ONE_CNT;
                        if (r_q.rem == ONE_CNT) begin
                            r_d.done = 1'b1;
                            r_d.st   = SW_IDLE;
                        end else begin
                            r_d.st = SW_ISSUE;
                        end
                    end
                end
            end
            default: r_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SW_IDLE, addr: '0, rem: '0, lba: 1'b0, spt: '0,
                     heads: '0, corr: 1'b0, unc: 1'b0, err: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o  = (r_q.st == SW_ISSUE);
    assign addr_o = r_q.addr;
    assign rem_o  = r_q.rem;
    assign corr_o = r_q.corr;
    assign unc_o  = r_q.unc;
    assign err_o  = r_q.err;
    assign done_o = r_q.done;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R7
    unc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SW_WAIT && sec_done_i && sec_unc_i) |=>
        (addr_o == $past(addr_o) && rem_o == $past(rem_o) && unc_o && err_o && done_o));

    // R5
    ok_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (rem_o == '0));

    // R6
    corr_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SW_WAIT && sec_done_i && sec_corr_i && !sec_unc_i && rem_o > ONE_CNT)
        |=> (req_o && corr_o));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SW_ISSUE && start_i) |=> ($stable(addr_o) && $stable(rem_o)));

    // R7
    unc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unc_o |-> err_o);

endmodule

// File: tb/sector_walker_tb.sv
`timescale 1ns/1ps
module sector_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        lba_mode_i = 1'b0;
    logic [7:0]  sec_num_i = '0, cyl_lo_i = '0, cyl_hi_i = '0, count_i = '0, spt_i = '0;
    logic [3:0]  head_i = '0;
    logic [4:0]  heads_i = '0;
    logic        sec_done_i = 1'b0, sec_corr_i = 1'b0, sec_unc_i = 1'b0;
    logic        req_o, corr_o, unc_o, err_o, done_o;
    logic [27:0] addr_o;
    logic [8:0]  rem_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sector_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lba_mode_i(lba_mode_i),
        .sec_num_i(sec_num_i), .cyl_lo_i(cyl_lo_i), .cyl_hi_i(cyl_hi_i),
        .head_i(head_i), .count_i(count_i), .spt_i(spt_i), .heads_i(heads_i),
        .sec_done_i(sec_done_i), .sec_corr_i(sec_corr_i), .sec_unc_i(sec_unc_i),
        .req_o(req_o), .addr_o(addr_o), .rem_o(rem_o), .corr_o(corr_o),
        .unc_o(unc_o), .err_o(err_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [27:0] step_ref(logic [27:0] a, bit lba, int spt, int heads);
        int s, h, c;
        if (lba) return a + 28'd1;
        s = int'(a[7:0]); c = int'(a[23:8]); h = int'(a[27:24]);
        if (s == spt) begin
            s = 1;
            if (h + 1 == heads) begin h = 0; c = (c + 1) & 16'hFFFF; end
            else h = h + 1;
        end else s = (s + 1) & 8'hFF;
        return {h[3:0], c[15:0], s[7:0]};
    endfunction

    // unc_at/corr_at: sector index to force a flag, -1 none; rnd adds random flags
    task automatic run_xfer(input bit lba, input logic [7:0] sec, input logic [7:0] clo,
                            input logic [7:0] chi, input logic [3:0] hd, input logic [7:0] cnt,
                            input logic [7:0] spt, input logic [4:0] heads,
                            input int unc_at, input int corr_at, input bit rnd);
        logic [27:0] ea;
        int er;
        bit corr_seen, c, u, fin;
        ea = {hd, chi, clo, sec};
        er = (cnt == 0) ? 256 : int'(cnt);
        corr_seen = 0;
        @(negedge clk);
        start_i = 1; lba_mode_i = lba; sec_num_i = sec; cyl_lo_i = clo; cyl_hi_i = chi;
        head_i = hd; count_i = cnt; spt_i = spt; heads_i = heads;
        @(negedge clk);
        start_i = 0;
        // R10: fields change after start and must not matter
        sec_num_i = 8'($urandom); cyl_lo_i = 8'($urandom); count_i = 8'($urandom);
        lba_mode_i = ~lba; spt_i = 8'($urandom);
        chk("R10 flags cleared at start", {corr_o, unc_o, err_o}, 3'b000);
        chk("R1 count after start", rem_o, er);
        chk("R2 start address packing", addr_o, ea);
        for (int s = 0; s < 300; s++) begin
            chk("R8 request pulse", req_o, 1'b1);
            chk("R3/R4 address per sector", addr_o, ea);
            chk("R5 remaining per sector", rem_o, er);
            if (s % 3 == 1) begin
                start_i = 1; count_i = 8'd7; sec_num_i = 8'h55;
            end
            @(negedge clk);
            start_i = 0;
            chk("R8 single request outstanding", req_o, 1'b0);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            u = (s == unc_at) || (rnd && ($urandom_range(0, 39) == 0));
            c = (s == corr_at) || (rnd && ($urandom_range(0, 5) == 0));
            sec_done_i = 1; sec_corr_i = c; sec_unc_i = u;
            @(negedge clk);
            sec_done_i = 0; sec_corr_i = 0; sec_unc_i = 0;
            fin = 0;
            if (u) begin
                chk("R7 unc flags", {unc_o, err_o}, 2'b11);
                chk("R7 failing address held", addr_o, ea);
                chk("R7 remaining held", rem_o, er);
                chk("R9 done on failure", done_o, 1'b1);
                fin = 1;
            end else begin
                if (c) corr_seen = 1;
                ea = step_ref(ea, lba, int'(spt), int'(heads));
                er = er - 1;
                chk("R6 corr sticky", corr_o, corr_seen);
                if (er == 0) begin
                    chk("R9 done on success", done_o, 1'b1);
                    chk("R5 success end", {rem_o, err_o, unc_o}, 11'b0);
                    chk("R3/R4 final address", addr_o, ea);
                    fin = 1;
                end else begin
                    chk("R9 no early done", done_o, 1'b0);
                end
            end
            if (fin) begin
                @(negedge clk);
                chk("R9 done one cycle", done_o, 1'b0);
                chk("R8 no request when idle", req_o, 1'b0);
                // R8: stray done strobe while idle has no effect
                sec_done_i = 1; sec_unc_i = 1;
                @(negedge clk);
                sec_done_i = 0; sec_unc_i = 0;
                @(negedge clk);
                chk("R8 idle done ignored", {unc_o, rem_o}, {u, 9'(er)});
                chk("R8 idle done ignored addr", addr_o, ea);
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {req_o, done_o, corr_o, unc_o, err_o}, 5'b0);
        chk("R11 reset addr", addr_o, 28'h0);
        chk("R11 reset rem", rem_o, 9'h0);
        rst_n = 1;
        @(negedge clk);
        // directed: CHS cylinder carry
        run_xfer(0, 8'd3, 8'hFF, 8'h00, 4'd1, 8'd5, 8'd3, 5'd2, -1, -1, 0);
        // directed: LBA byte carries
        run_xfer(1, 8'hFE, 8'hFF, 8'hFF, 4'h0, 8'd4, 8'd1, 5'd1, -1, -1, 0);
        // directed: corr mid transfer continues
        run_xfer(1, 8'h10, 8'h00, 8'h00, 4'h0, 8'd4, 8'd1, 5'd1, -1, 1, 0);
        // directed: unc on inner sector
        run_xfer(0, 8'd1, 8'h02, 8'h00, 4'd0, 8'd6, 8'd2, 5'd3, 2, -1, 0);
        // directed: count 0 means 256
        run_xfer(1, 8'h00, 8'h00, 8'h01, 4'h2, 8'd0, 8'd1, 5'd1, -1, -1, 0);
        for (int i = 0; i < 40; i++) begin
            bit lb;
            logic [7:0] sp;
            logic [4:0] hs;
            lb = 1'($urandom);
            sp = 8'($urandom_range(1, 63));
            hs = 5'($urandom_range(1, 16));
            run_xfer(lb, lb ? 8'($urandom) : 8'($urandom_range(1, int'(sp))),
                     8'($urandom), 8'($urandom),
                     lb ? 4'($urandom) : 4'($urandom_range(0, int'(hs) - 1)),
                     8'($urandom_range(1, 12)), sp, hs, -1, -1, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule